// File: doc/BRIEF.md
# Dual-Port Hardware Token Bank

This block holds a small bank of ownership tokens shared by two independent processor ports, called left and right. A processor claims a token by writing 0 to it and gives it back by writing 1; it learns whether the claim succeeded by reading the token afterwards. A token reads 0 on the side that holds it and 1 everywhere else, so the usual protocol is write-then-read: write 0, read back, and proceed only if the read returned all zeros.

Each token is built from a pair of per-side request latches feeding an ownership state. A claim made while the other side holds the token is not lost. It stays latched as pending, and the token passes to that side on the same clock edge on which the owner writes 1. When both sides claim a free token in the same cycle, a fixed rule gives it to the left port. Each port also has a read latch. The value seen in the first cycle of a read is held for as long as that read stays active, so a read cannot change part-way through because of a write from the other side. All inputs are sampled in a single clock domain.

Top module: `dp_token_bank`

## Requirements
- R1: There are NUM_FLAGS (default 8) tokens. A port addresses the bank only while its active-low token select is 0, and only address bits [FLAG_W-1:0] (bits [2:0] by default) choose the token. All higher address bits have no effect.
- R2: A write takes effect on the rising clock edge when the port's select is 0 and its active-low write strobe is 0. Only data bit 0 matters: 0 requests the token and 1 releases it or cancels a request. All other data bits have no effect.
- R3: When one side writes 0 to a free token, that side reads the token as all zeros from the next cycle on, and the other side reads it as all ones.
- R4: An owned token keeps its owner until the owner writes 1. Writes from the other side never change what either side reads while the owner holds the token.
- R5: A 0 written by the locked-out side is held as pending. When the owner writes 1, ownership moves to the pending side on that same edge, and from the next cycle that side reads all zeros.
- R6: When the owner writes 1 and no request is pending on the other side, the token becomes free and both sides read all ones.
- R7: A 1 written by the non-owning side cancels its pending request, so a later release by the owner leaves the token free.
- R8: Read data is the token value copied into every data bit (all ones or all zeros). A port drives data only while its select is 0, its active-low read enable is 0 and its write strobe is 1 (read mode). Otherwise its data output is all zeros.
- R9: A port's read value is taken in the first cycle its read becomes active. It is held unchanged while select and read enable stay 0, even if the other side writes or the address changes. Dropping either signal for one cycle lets the next read see the current state.
- R10: If both sides write 0 to the same free token in the same cycle, the left port gets it and the right port's request stays pending.
- R11: After reset every request latch holds 1, so every token is free and reads as all ones from both sides.
- R12: Tokens are independent: a write to one token leaves the state of every other token unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_tsel_n | input | 1 | Left token select, active low |
| l_rd_en_n | input | 1 | Left read enable, active low |
| l_wr_n | input | 1 | Left write strobe, active low (1 = read mode) |
| l_addr | input | ADDR_W | Left address; only the low FLAG_W bits are used |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left read data, the token value copied into every bit |
| r_tsel_n | input | 1 | Right token select, active low |
| r_rd_en_n | input | 1 | Right read enable, active low |
| r_wr_n | input | 1 | Right write strobe, active low (1 = read mode) |
| r_addr | input | ADDR_W | Right address; only the low FLAG_W bits are used |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right read data, the token value copied into every bit |

## Verification
The bench goes after four corner cases:
- Same-cycle claims on a free token. A design that got this wrong would hand the token to both sides, or to the right port.
- Release while the other side has a request pending. A wrong design would free the token, or pass it one cycle late, instead of moving it on that same edge.
- A cancelled pending request. A wrong design would hand the token to a side that has already withdrawn its request.
- A held read during which the other side changes ownership. A wrong design would let the data change mid-read, or keep showing the stale value after the read is dropped.

The bench also sets the high address bits and the upper data bits, to catch designs that decode them. Long runs of seeded random traffic on both ports are checked against a reference model kept in the bench.

// File: rtl/tok_bank_pkg.sv
package tok_bank_pkg;
   typedef enum logic [1:0] {
      TOK_FREE  = 2'd0,
      TOK_LEFT  = 2'd1,
      TOK_RIGHT = 2'd2
   } tok_own_e;
endpackage

// File: rtl/tok_flag_cell.sv
module tok_flag_cell
   import tok_bank_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_l,
   input  logic wd_l,
   input  logic wr_r,
   input  logic wd_r,
   output logic flag_l,
   output logic flag_r
);
   logic     req_l_q, req_r_q, req_l_nx, req_r_nx;
   tok_own_e own_q, own_nx;

   // request latches: 0 = wants the token, 1 = idle
   always_comb begin
      req_l_nx = wr_l ? wd_l : req_l_q;
      req_r_nx = wr_r ? wd_r : req_r_q;
   end

   // ownership: left wins a same-cycle tie on a free token
   always_comb begin
      unique case (own_q)
         TOK_FREE:  own_nx = !req_l_nx ? TOK_LEFT  : (!req_r_nx ? TOK_RIGHT : TOK_FREE);
         TOK_LEFT:  own_nx = !req_l_nx ? TOK_LEFT  : (!req_r_nx ? TOK_RIGHT : TOK_FREE);
         TOK_RIGHT: own_nx = !req_r_nx ? TOK_RIGHT : (!req_l_nx ? TOK_LEFT  : TOK_FREE);
         default:   own_nx = TOK_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_l_q <= 1'b1;
         req_r_q <= 1'b1;
         own_q   <= TOK_FREE;
      end else begin
         req_l_q <= req_l_nx;
         req_r_q <= req_r_nx;
         own_q   <= own_nx;
      end
   end

   assign flag_l = (own_q != TOK_LEFT);
   assign flag_r = (own_q != TOK_RIGHT);

   a_r4_left_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == TOK_LEFT && !(wr_l && wd_l)) |=> own_q == TOK_LEFT);
   a_r4_right_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == TOK_RIGHT && !(wr_r && wd_r)) |=> own_q == TOK_RIGHT);
   a_r5_handover: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == TOK_LEFT && wr_l && wd_l && !req_r_q && !(wr_r && wd_r))
      |=> own_q == TOK_RIGHT);
   a_r6_release_free: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == TOK_LEFT && wr_l && wd_l && req_r_q && !(wr_r && !wd_r))
      |=> own_q == TOK_FREE);
   a_r10_left_tie: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == TOK_FREE && wr_l && !wd_l && wr_r && !wd_r)
      |=> (own_q == TOK_LEFT && !req_r_q));
endmodule

// File: rtl/tok_read_port.sv
module tok_read_port #(
   parameter int NUM_FLAGS = 8,
   parameter int DATA_W    = 16,
   localparam int FLAG_W   = $clog2(NUM_FLAGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tsel_n,
   input  logic                 rd_en_n,
   input  logic                 wr_n,
   input  logic [FLAG_W-1:0]    idx,
   input  logic [NUM_FLAGS-1:0] flags,
   output logic [DATA_W-1:0]    rdata
);
   if (DATA_W < 1) begin : g_bad_width
      $error("tok_read_port: DATA_W must be at least 1");
   end

   logic act, hold_q, held_q, live, bit_v;

   assign act  = !tsel_n && !rd_en_n && wr_n;
   assign live = flags[idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         held_q <= 1'b1;
      end else begin
         hold_q <= act;
         if (act && !hold_q) held_q <= live;
      end
   end

   assign bit_v = hold_q ? held_q : live;
   assign rdata = act ? {DATA_W{bit_v}} : '0;

   a_r9_read_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (act && $past(act)) |-> $stable(rdata));
   a_r8_replicated: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata == '0) || (rdata == '1));
endmodule

// File: rtl/dp_token_bank.sv
module dp_token_bank #(
   parameter int NUM_FLAGS = 8,
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 16,
   localparam int FLAG_W   = $clog2(NUM_FLAGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_tsel_n,
   input  logic              l_rd_en_n,
   input  logic              l_wr_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_tsel_n,
   input  logic              r_rd_en_n,
   input  logic              r_wr_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   if (NUM_FLAGS < 2 || (1 << FLAG_W) != NUM_FLAGS) begin : g_bad_count
      $error("dp_token_bank: NUM_FLAGS must be a power of two, at least 2");
   end
   if (ADDR_W < FLAG_W) begin : g_bad_addr
      $error("dp_token_bank: ADDR_W too small for NUM_FLAGS");
   end

   logic [FLAG_W-1:0]    l_idx, r_idx;
   logic                 l_wen, r_wen;
   logic [NUM_FLAGS-1:0] wr_l, wr_r, flag_l, flag_r;
   logic                 unused_bits;

   assign l_idx = l_addr[FLAG_W-1:0];
   assign r_idx = r_addr[FLAG_W-1:0];
   assign l_wen = !l_tsel_n && !l_wr_n;
   assign r_wen = !r_tsel_n && !r_wr_n;
   assign unused_bits = ^{l_addr, l_wdata, r_addr, r_wdata};

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      assign wr_l[g] = l_wen && (l_idx == FLAG_W'(g));
      assign wr_r[g] = r_wen && (r_idx == FLAG_W'(g));
      tok_flag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_l   (wr_l[g]),
         .wd_l   (l_wdata[0]),
         .wr_r   (wr_r[g]),
         .wd_r   (r_wdata[0]),
         .flag_l (flag_l[g]),
         .flag_r (flag_r[g])
      );
   end

   tok_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
      .clk (clk), .rst_n (rst_n), .tsel_n (l_tsel_n), .rd_en_n (l_rd_en_n),
      .wr_n (l_wr_n), .idx (l_idx), .flags (flag_l), .rdata (l_rdata)
   );
   tok_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
      .clk (clk), .rst_n (rst_n), .tsel_n (r_tsel_n), .rd_en_n (r_rd_en_n),
      .wr_n (r_wr_n), .idx (r_idx), .flags (flag_r), .rdata (r_rdata)
   );

   // R1: a single cycle never writes more than one token per side
   a_r1_one_hot_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_l) && $onehot0(wr_r));
endmodule

// File: tb/tb_dp_token_bank.sv
module tb_dp_token_bank;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NF = 8;
   localparam int AW = 13;
   localparam int DW = 16;
   localparam logic [DW-1:0] ONES = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_tsel_n = 1'b1, l_rd_en_n = 1'b1, l_wr_n = 1'b1;
   logic r_tsel_n = 1'b1, r_rd_en_n = 1'b1, r_wr_n = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_own[NF];          // 0 free, 1 left, 2 right
   bit m_rl[NF], m_rr[NF];
   bit m_hold[2], m_held[2];

   always #2 clk = ~clk;   // 250 MHz

   dp_token_bank #(.NUM_FLAGS(NF), .ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n),
      .l_tsel_n(l_tsel_n), .l_rd_en_n(l_rd_en_n), .l_wr_n(l_wr_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_tsel_n(r_tsel_n), .r_rd_en_n(r_rd_en_n), .r_wr_n(r_wr_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
   );

   function automatic bit live_bit(int side, int f);
      return (side == 0) ? (m_own[f] != 1) : (m_own[f] != 2);
   endfunction

   function automatic logic [DW-1:0] exp_rd(int side, bit sel_n, bit oe_n, bit we_n,
                                             logic [AW-1:0] a);
      bit v;
      if (sel_n || oe_n || !we_n) return '0;
      v = m_hold[side] ? m_held[side] : live_bit(side, int'(a[2:0]));
      return v ? ONES : '0;
   endfunction

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int f = 0; f < NF; f++) begin
         m_own[f] = 0; m_rl[f] = 1; m_rr[f] = 1;
      end
      m_hold = '{0, 0};
      m_held = '{1, 1};
   endtask

   task automatic model_edge();
      bit act[2];
      act[0] = !l_tsel_n && !l_rd_en_n && l_wr_n;
      act[1] = !r_tsel_n && !r_rd_en_n && r_wr_n;
      for (int s = 0; s < 2; s++) begin
         int ix;
         ix = (s == 0) ? int'(l_addr[2:0]) : int'(r_addr[2:0]);
         if (act[s] && !m_hold[s]) m_held[s] = live_bit(s, ix);
         m_hold[s] = act[s];
      end
      for (int f = 0; f < NF; f++) begin
         bit nl, nr;
         nl = (!l_tsel_n && !l_wr_n && int'(l_addr[2:0]) == f) ? l_wdata[0] : m_rl[f];
         nr = (!r_tsel_n && !r_wr_n && int'(r_addr[2:0]) == f) ? r_wdata[0] : m_rr[f];
         case (m_own[f])
            1: if (nl) m_own[f] = !nr ? 2 : 0;
            2: if (nr) m_own[f] = !nl ? 1 : 0;
            default: m_own[f] = !nl ? 1 : (!nr ? 2 : 0);
         endcase
         m_rl[f] = nl; m_rr[f] = nr;
      end
   endtask

   // one cycle: drive at falling edge, check mid-cycle, advance model
   task automatic step(string tag,
                       bit ls, bit lo, bit lw, logic [AW-1:0] la, logic [DW-1:0] ld,
                       bit rs, bit ro, bit rw, logic [AW-1:0] ra, logic [DW-1:0] rd);
      @(negedge clk);
      l_tsel_n = ls; l_rd_en_n = lo; l_wr_n = lw; l_addr = la; l_wdata = ld;
      r_tsel_n = rs; r_rd_en_n = ro; r_wr_n = rw; r_addr = ra; r_wdata = rd;
      #1;
      chk({tag, " left"},  l_rdata, exp_rd(0, ls, lo, lw, la));
      chk({tag, " right"}, r_rdata, exp_rd(1, rs, ro, rw, ra));
      model_edge();
   endtask

   task automatic idle(string tag);
      step(tag, 1, 1, 1, '0, '0, 1, 1, 1, '0, '0);
   endtask

   task automatic lwrite(string tag, logic [AW-1:0] a, logic [DW-1:0] d);
      step(tag, 0, 1, 0, a, d, 1, 1, 1, '0, '0);
   endtask

   task automatic rwrite(string tag, logic [AW-1:0] a, logic [DW-1:0] d);
      step(tag, 1, 1, 1, '0, '0, 0, 1, 0, a, d);
   endtask

   task automatic read_both(string tag, logic [AW-1:0] a);
      step(tag, 0, 0, 1, a, '0, 0, 0, 1, a, '0);
      idle(tag);
   endtask

   task automatic expect_both(string tag, logic [AW-1:0] a,
                              logic [DW-1:0] el, logic [DW-1:0] er);
      @(negedge clk);
      l_tsel_n = 0; l_rd_en_n = 0; l_wr_n = 1; l_addr = a;
      r_tsel_n = 0; r_rd_en_n = 0; r_wr_n = 1; r_addr = a;
      #1;
      chk({tag, " directed left"},  l_rdata, el);
      chk({tag, " directed right"}, r_rdata, er);
      model_edge();
      idle(tag);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h1357);
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset idle left", l_rdata, '0);
      chk("R8 reset idle right", r_rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: all tokens free after reset
      for (int f = 0; f < NF; f++) expect_both("R11", AW'(f), ONES, ONES);

      // R3 + R1: left claims token 2 using an address with high bits set
      lwrite("R3 claim", 13'h1F02, 16'h0000);
      expect_both("R3", 13'h0002, '0, ONES);
      expect_both("R1 high bits", 13'h0A02, '0, ONES);

      // R4: right release/request do not disturb the owner
      rwrite("R4 stray release", 13'h0002, 16'h0001);
      expect_both("R4", 13'h0002, '0, ONES);
      rwrite("R5 pend", 13'h0002, 16'h0000);
      expect_both("R4 pending", 13'h0002, '0, ONES);

      // R5: release hands over at once
      lwrite("R5 release", 13'h0002, 16'h0001);
      expect_both("R5", 13'h0002, ONES, '0);
      // R6: release with nothing pending frees the token
      rwrite("R6 release", 13'h0002, 16'h0001);
      expect_both("R6", 13'h0002, ONES, ONES);

      // R7: cancelled request does not receive the token
      lwrite("R7 claim", 13'h0005, 16'h0000);
      rwrite("R7 pend", 13'h0005, 16'h0000);
      rwrite("R7 cancel", 13'h0005, 16'h0001);
      lwrite("R7 release", 13'h0005, 16'h0001);
      expect_both("R7", 13'h0005, ONES, ONES);

      // R10: same-cycle claims, left wins, right pending
      step("R10 tie", 0, 1, 0, 13'h0003, 16'h0000, 0, 1, 0, 13'h0003, 16'h0000);
      expect_both("R10", 13'h0003, '0, ONES);
      lwrite("R10 release", 13'h0003, 16'h0001);
      expect_both("R10 pending kept", 13'h0003, ONES, '0);

      // R12: neighbours untouched
      expect_both("R12", 13'h0004, ONES, ONES);
      expect_both("R12 b", 13'h0002, ONES, ONES);

      // R2: only bit 0 of write data matters
      lwrite("R2 claim", 13'h0006, 16'hFFFE);
      expect_both("R2", 13'h0006, '0, ONES);
      lwrite("R2 release", 13'h0006, 16'h0001);
      expect_both("R2 freed", 13'h0006, ONES, ONES);

      // R9: held read on the right while ownership moves to it
      lwrite("R9 claim", 13'h0007, 16'h0000);
      rwrite("R9 pend", 13'h0007, 16'h0000);
      step("R9 read start", 1, 1, 1, '0, '0, 0, 0, 1, 13'h0007, '0);
      step("R9 owner release", 0, 1, 0, 13'h0007, 16'h0001, 0, 0, 1, 13'h0007, '0);
      @(negedge clk);
      l_tsel_n = 1; l_rd_en_n = 1; l_wr_n = 1;
      r_tsel_n = 0; r_rd_en_n = 0; r_wr_n = 1; r_addr = 13'h0001;
      #1;
      chk("R9 held through write and address change", r_rdata, ONES);
      model_edge();
      idle("R9");
      expect_both("R9 reread", 13'h0007, ONES, '0);

      // R8: write mode and disabled read drive zeros
      step("R8 modes", 0, 0, 0, 13'h0004, 16'h0001, 0, 1, 1, 13'h0007, '0);
      @(negedge clk);
      l_tsel_n = 0; l_rd_en_n = 0; l_wr_n = 0; l_addr = 13'h0004; l_wdata = 16'h0001;
      r_tsel_n = 1; r_rd_en_n = 0; r_wr_n = 1; r_addr = 13'h0007;
      #1;
      chk("R8 write mode zero", l_rdata, '0);
      chk("R8 deselected zero", r_rdata, '0);
      model_edge();
      idle("R8");

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         bit ls, lo, lw, rs, ro, rw;
         ls = ($urandom % 10) >= 7; lo = ($urandom % 10) >= 7; lw = ($urandom % 10) >= 4;
         rs = ($urandom % 10) >= 7; ro = ($urandom % 10) >= 7; rw = ($urandom % 10) >= 4;
         step("R8 R9 random", ls, lo, lw, AW'($urandom), DW'($urandom),
              rs, ro, rw, AW'($urandom), DW'($urandom));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule